// File: doc/BRIEF.md
# Scan-Line Pixel Transfer Port

This block connects a byte-wide processor register port to a pixel memory stream. Software sets a line width in pixels, picks a byte format (packed 24-bit RGB or YUV 4:2:2 with shared chroma) and a direction, and then raises a start bit. From then on the block moves one scan line at a time through an internal line buffer. In write direction, software pushes the bytes of a line into the data register, and the block hands the assembled pixels to memory one word per handshake. In read direction, the block pulls one line of pixel words from memory, and software drains them byte by byte.

A status flag tells software when the current line is complete. In write direction that means every pixel has been accepted by memory. In read direction it means the whole line has been fetched. The start bit stays set between lines, so the block rearms itself for the next line without any further programming. Clearing the start bit ends the whole multi-line job.

Top module: `lxfer_port`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the data register (address 3) reads 0x00, and neither `pw_valid` nor `pr_ready` is asserted.
- R2: Address 1 holds the low byte and address 2 the high byte of the line width; both read back as written, and the width is {high, low} (0x00 then 0x04 gives 1024). A run uses widths from 1 to DEPTH.
- R3: With control bit 3 (format) = 0 and bit 2 (direction) = 0, each three data writes R, G, B form the pixel word {R[23:16], G[15:8], B[7:0]}. Pixels leave in order on `pw_data`, and a word offered on `pw_valid` stays unchanged until `pw_ready` accepts it.
- R4: With format = 1 in write direction, bytes arrive in groups Y_even, UV, Y_odd, UV_repeat. Each pixel word is {8'h00, Y[15:8], UV[7:0]}. The odd pixel carries the even pixel's UV, and the value of the repeated UV byte is discarded. An odd width ends the line after 2*N bytes.
- R5: Control bit 0 (ready) rises once all N pixels of a line have been accepted by memory (write) or fetched (read). It falls on the first data-register access of the next line.
- R6: Data writes made after the last byte of a line and before ready rises are ignored, and they do not become bytes of the next line.
- R7: In read direction `pr_ready` is high while a line is being fetched. Exactly N words are taken, and no more are taken until software has drained the line.
- R8: In read direction with format = 0, the data register returns R, G, B of each pixel in order, from bits [23:16], [15:8] and [7:0] of the fetched word.
- R9: In read direction with format = 1, the data register returns Y_even, UV_even, Y_odd, UV_even for each pair, taken from bits [15:8] and [7:0] of the fetched words. The odd word's UV and bits [23:16] are not used.
- R10: A data-register read while no fetched line is waiting returns 0x00 and changes nothing.
- R11: Writing the control register with bit 1 (start) = 0 stops the job at once. It clears ready and the byte and pixel positions, and no partial pixel reaches memory. The next start begins at byte 0 of a line.
- R12: While start remains 1, each completed line automatically prepares the next one (a new fill in write direction, a new fetch in read direction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe (side effects on data register) |
| host_addr | input | 2 | 0 control/status, 1 width low, 2 width high, 3 data |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data, combinational from address and state |
| pw_valid | output | 1 | Pixel word offered to memory |
| pw_ready | input | 1 | Memory accepts the offered word |
| pw_data | output | 24 | Pixel word to memory |
| pr_valid | input | 1 | Memory offers a pixel word |
| pr_ready | output | 1 | Block takes the offered word |
| pr_data | input | 24 | Pixel word from memory |

## Verification
RGB lines are written with memory acceptance held high, toggling every cycle, and stalled. A stall is used to land junk writes inside the push window, so any capture of ignored bytes shows up as a shifted first pixel in the next line. YUV lines use an odd width and a repeated chroma byte that differs from the first one, which separates "reuse the even chroma" from "take the latest byte". Read lines supply memory words whose top byte and odd-pixel chroma are nonzero, so that a wrong byte lane or chroma source shows in the drained bytes. A mid-line stop followed by a restart shows whether stale byte positions survive.

// File: rtl/lxfer_port.sv
module lxfer_port #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic        host_re,
  input  logic [1:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        pw_valid,
  input  logic        pw_ready,
  output logic [23:0] pw_data,
  input  logic        pr_valid,
  output logic        pr_ready,
  input  logic [23:0] pr_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_PUSH, S_WDONE, S_FETCH, S_HOLD} st_t;

  st_t         st;
  logic [7:0]  wlo, whi, b0, b1;
  logic        run, dir, fmt, ready;
  logic [15:0] pc;
  logic [1:0]  ph;
  logic [23:0] lbuf [DEPTH];

  wire [15:0]   width   = {whi, wlo};
  wire          last_px = (pc == width - 16'd1);
  wire          ctl_wr  = host_we && host_addr == 2'd0;
  wire          dat_wr  = host_we && host_addr == 2'd3;
  wire          dat_rd  = host_re && host_addr == 2'd3;
  wire [AW-1:0] idx     = pc[AW-1:0];
  wire [23:0]   cur     = lbuf[idx];
  wire          pdone   = fmt ? ph[0] : (ph == 2'd2);
  wire [1:0]    ph_next = (fmt && ph == 2'd1) ? 2'd2 : 2'd0;

  wire [23:0] wword = !fmt       ? {b0, b1, host_wdata} :
                      (ph == 2'd1) ? {8'h00, b0, host_wdata} :
                                     {8'h00, b0, b1};

  logic [7:0] rbyte;
  always_comb begin
    if (fmt)
      rbyte = (ph == 2'd3) ? b1 : (ph[0] ? cur[7:0] : cur[15:8]);
    else
      rbyte = (ph == 2'd0) ? cur[23:16] : (ph == 2'd1) ? cur[15:8] : cur[7:0];
  end

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = {4'b0000, fmt, dir, run, ready};
      2'd1:    host_rdata = wlo;
      2'd2:    host_rdata = whi;
      default: host_rdata = (st == S_HOLD) ? rbyte : 8'h00;
    endcase
  end

  assign pw_valid = (st == S_PUSH);
  assign pw_data  = cur;
  assign pr_ready = (st == S_FETCH);

  always_ff @(posedge clk) begin
    if (st == S_FILL && dat_wr && pdone) lbuf[idx] <= wword;
    if (st == S_FETCH && pr_valid)       lbuf[idx] <= pr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wlo <= '0; whi <= '0; b0 <= '0; b1 <= '0;
      run <= 1'b0; dir <= 1'b0; fmt <= 1'b0; ready <= 1'b0;
      pc <= '0; ph <= '0;
    end else begin
      if (host_we && host_addr == 2'd1) wlo <= host_wdata;
      if (host_we && host_addr == 2'd2) whi <= host_wdata;
      if (ctl_wr) begin
        run <= host_wdata[1];
        dir <= host_wdata[2];
        fmt <= host_wdata[3];
      end
      if (ctl_wr && !host_wdata[1]) begin
        st <= S_IDLE; ready <= 1'b0; pc <= '0; ph <= '0;
      end else if (ctl_wr && !run) begin
        st <= host_wdata[2] ? S_FETCH : S_FILL;
        ready <= 1'b0; pc <= '0; ph <= '0;
      end else begin
        case (st)
          S_FILL: if (dat_wr) begin
            if (ph == 2'd0 || (fmt && ph == 2'd2)) b0 <= host_wdata;
            if (ph == 2'd1) b1 <= host_wdata;
            if (pdone) begin
              ph <= ph_next;
              if (last_px) begin
                st <= S_PUSH; pc <= '0; ph <= '0;
              end else pc <= pc + 16'd1;
            end else ph <= ph + 2'd1;
          end
          S_PUSH: if (pw_ready) begin
            if (last_px) begin
              st <= S_WDONE; ready <= 1'b1; pc <= '0;
            end else pc <= pc + 16'd1;
          end
          S_WDONE: if (dat_wr) begin
            ready <= 1'b0; b0 <= host_wdata; ph <= 2'd1; st <= S_FILL;
          end
          S_FETCH: if (pr_valid) begin
            if (last_px) begin
              st <= S_HOLD; ready <= 1'b1; pc <= '0; ph <= '0;
            end else pc <= pc + 16'd1;
          end
          S_HOLD: if (dat_rd) begin
            ready <= 1'b0;
            if (fmt && ph == 2'd1) b1 <= cur[7:0];
            if (pdone) begin
              ph <= ph_next;
              if (last_px) begin
                st <= S_FETCH; pc <= '0; ph <= '0;
              end else pc <= pc + 16'd1;
            end else ph <= ph + 2'd1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lxfer_port_chk.sv
module lxfer_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic        host_re,
  input logic [1:0]  host_addr,
  input logic [7:0]  host_rdata,
  input logic        pw_valid,
  input logic        pw_ready,
  input logic [23:0] pw_data,
  input logic        pr_ready,
  input logic        run,
  input logic        ready
);
  a_r3_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid && !pw_ready |=> pw_valid && $stable(pw_data));

  a_r5_ready_sides_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !pw_valid && !pr_ready);

  a_r5_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !((host_we || host_re) && host_addr == 2'd3) && !(host_we && host_addr == 2'd0)
    |=> ready);

  a_r10_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pr_ready && host_re && host_addr == 2'd3 |-> host_rdata == 8'h00);

  a_r11_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !pw_valid && !pr_ready && !ready);

  a_r12_ready_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> run);
endmodule

bind lxfer_port lxfer_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
  .host_addr(host_addr), .host_rdata(host_rdata), .pw_valid(pw_valid),
  .pw_ready(pw_ready), .pw_data(pw_data), .pr_ready(pr_ready),
  .run(run), .ready(ready)
);

// File: tb/test_lxfer_port.sv
module test_lxfer_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic pw_valid, pw_ready = 1'b0;
  logic [23:0] pw_data;
  logic pr_valid = 1'b0, pr_ready;
  logic [23:0] pr_data = '0;

  always #4 clk = ~clk;

  lxfer_port i_lxfer_port (.*);

  int tests = 0, fails = 0;
  int bp = 0;
  bit feed_en = 1'b1;
  string cur_req = "R3";
  logic [23:0] exp_px[$];
  logic [23:0] mem_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    pw_ready = (bp == 0) ? 1'b1 : (bp == 1) ? ~pw_ready : 1'b0;
    if (rst_n && pw_valid && pw_ready) begin
      if (exp_px.size() == 0) chk(1'b0, "R11 unexpected pixel", pw_data, 0);
      else begin
        logic [23:0] e;
        e = exp_px.pop_front();
        chk(pw_data == e, cur_req, pw_data, e);
      end
    end
    pr_valid = feed_en && mem_q.size() > 0;
    pr_data  = pr_valid ? mem_q[0] : 24'h0;
    if (rst_n && pr_valid && pr_ready) void'(mem_q.pop_front());
  end

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_re = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk); host_re = 1'b0;
  endtask

  task automatic wait_ready(input string req);
    logic [7:0] v;
    v = 8'h00;
    for (int k = 0; k < 1000; k++) begin
      host_rd(2'd0, v);
      if (v[0]) break;
    end
    chk(v[0] == 1'b1, req, v[0], 1);
  endtask

  task automatic wline_rgb(input int n, input logic [7:0] base, input bit chk_clear);
    logic [7:0] v;
    for (int p = 0; p < n; p++) begin
      logic [7:0] r, g, b;
      r = base + 8'(p * 3); g = r + 8'd1; b = r + 8'd2;
      exp_px.push_back({r, g, b});
      host_wr(2'd3, r);
      if (p == 0 && chk_clear) begin
        host_rd(2'd0, v);
        chk(v[0] == 1'b0, "R5 ready clears on first write", v[0], 0);
      end
      host_wr(2'd3, g);
      host_wr(2'd3, b);
    end
  endtask

  task automatic wline_yuv(input int n, input logic [7:0] base);
    logic [7:0] uv;
    uv = 8'h00;
    for (int p = 0; p < n; p++) begin
      logic [7:0] y;
      y = base + 8'(p * 2);
      if (p % 2 == 0) begin
        uv = y ^ 8'h5A;
        host_wr(2'd3, y);
        host_wr(2'd3, uv);
      end else begin
        host_wr(2'd3, y);
        host_wr(2'd3, ~uv);
      end
      exp_px.push_back({8'h00, y, uv});
    end
  endtask

  task automatic rline(input int n, input bit yuv, input logic [7:0] base, input bit preload);
    logic [23:0] w[$];
    logic [7:0] v, e, uv;
    for (int p = 0; p < n; p++) begin
      logic [7:0] a;
      a = base + 8'(p * 3);
      w.push_back({a, a + 8'd1, a + 8'd2});
      if (preload) mem_q.push_back({a, a + 8'd1, a + 8'd2});
    end
    wait_ready("R5 read line fetched");
    chk(pr_ready == 1'b0, "R7 no fetch while line held", pr_ready, 0);
    uv = 8'h00;
    for (int p = 0; p < n; p++) begin
      if (!yuv) begin
        for (int k = 0; k < 3; k++) begin
          host_rd(2'd3, v);
          e = w[p][23 - 8*k -: 8];
          chk(v == e, "R8 rgb read byte", v, e);
          if (p == 0 && k == 0) begin
            host_rd(2'd0, v);
            chk(v[0] == 1'b0, "R5 ready clears on first read", v[0], 0);
          end
        end
      end else begin
        if (p % 2 == 0) uv = w[p][7:0];
        host_rd(2'd3, v);
        chk(v == w[p][15:8], "R9 yuv read Y", v, w[p][15:8]);
        host_rd(2'd3, v);
        chk(v == uv, "R9 yuv read shared UV", v, uv);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog R-any act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    host_rd(2'd0, v); chk(v == 8'h00, "R1 control after reset", v, 0);
    host_rd(2'd3, v); chk(v == 8'h00, "R1 data after reset", v, 0);
    chk(pw_valid == 1'b0 && pr_ready == 1'b0, "R1 memory sides idle", {pw_valid, pr_ready}, 0);

    host_wr(2'd1, 8'h00); host_wr(2'd2, 8'h04);
    host_rd(2'd1, v); chk(v == 8'h00, "R2 width low", v, 0);
    begin
      logic [7:0] h;
      host_rd(2'd2, h); chk(h == 8'h04, "R2 width high", h, 4);
      chk({h, v} == 16'd1024, "R2 combined width", {h, v}, 1024);
    end

    host_wr(2'd1, 8'd5); host_wr(2'd2, 8'd0);
    host_wr(2'd0, 8'h02);
    cur_req = "R3 rgb pixel"; bp = 1;
    wline_rgb(5, 8'h10, 1'b0);
    wait_ready("R5 write line done");
    chk(exp_px.size() == 0, "R5 all pixels accepted", exp_px.size(), 0);
    host_rd(2'd0, v); chk(v == 8'h03, "R12 start stays set", v, 3);
    cur_req = "R12 second line pixel";
    wline_rgb(5, 8'h30, 1'b1);
    wait_ready("R12 second line done");

    bp = 2; cur_req = "R6 pixel around ignored writes";
    wline_rgb(5, 8'h50, 1'b0);
    host_wr(2'd3, 8'hEE); host_wr(2'd3, 8'hEF);
    bp = 1;
    wait_ready("R6 line done after stall");
    bp = 0;
    wline_rgb(5, 8'h70, 1'b0);
    wait_ready("R6 next line clean");
    chk(exp_px.size() == 0, "R6 no extra pixels", exp_px.size(), 0);

    host_wr(2'd0, 8'h00);
    host_wr(2'd0, 8'h02);
    for (int k = 0; k < 4; k++) host_wr(2'd3, 8'hC0 + 8'(k));
    host_wr(2'd0, 8'h00);
    repeat (6) @(negedge clk);
    host_rd(2'd0, v); chk(v == 8'h00, "R11 stop clears status", v, 0);
    host_wr(2'd0, 8'h02);
    cur_req = "R11 restart pixel";
    wline_rgb(5, 8'hA0, 1'b0);
    wait_ready("R11 restart line done");
    chk(exp_px.size() == 0, "R11 restart complete", exp_px.size(), 0);

    host_wr(2'd0, 8'h00);
    host_wr(2'd1, 8'd3);
    host_wr(2'd0, 8'h0A);
    bp = 1; cur_req = "R4 yuv pixel";
    wline_yuv(3, 8'h20);
    wait_ready("R4 odd width line done after 2N bytes");
    host_wr(2'd1, 8'd4);
    wline_yuv(4, 8'h60);
    wait_ready("R4 even width line done");
    chk(exp_px.size() == 0, "R4 all yuv pixels", exp_px.size(), 0);
    bp = 0;

    host_wr(2'd0, 8'h00);
    feed_en = 1'b0;
    host_wr(2'd0, 8'h06);
    host_rd(2'd3, v); chk(v == 8'h00, "R10 underflow read", v, 0);
    host_rd(2'd0, v); chk(v == 8'h06, "R10 underflow leaves status", v, 6);
    chk(pr_ready == 1'b1, "R7 fetch requested", pr_ready, 1);
    for (int p = 0; p < 4; p++) mem_q.push_back({8'h80 + 8'(p * 3), 8'h81 + 8'(p * 3), 8'h82 + 8'(p * 3)});
    for (int p = 0; p < 4; p++) mem_q.push_back({8'h90 + 8'(p * 3), 8'h91 + 8'(p * 3), 8'h92 + 8'(p * 3)});
    feed_en = 1'b1;
    rline(4, 1'b0, 8'h80, 1'b0);
    chk(mem_q.size() == 4, "R7 exactly N words taken", mem_q.size(), 4);
    rline(4, 1'b0, 8'h90, 1'b0);
    chk(mem_q.size() == 0, "R12 second read line fetched", mem_q.size(), 0);
    host_rd(2'd3, v); chk(v == 8'h00, "R10 read after drain", v, 0);

    host_wr(2'd0, 8'h00);
    host_wr(2'd1, 8'd3);
    host_wr(2'd0, 8'h0E);
    rline(3, 1'b1, 8'h40, 1'b1);
    host_wr(2'd0, 8'h00);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule